// File: doc/BRIEF.md
# Receive Queue with Per-Word Status and Request Routing

This block sits between a serial receiver core and the register interface of a UART. Each byte that the receiver delivers goes into a first-in first-out queue. Two error marks travel with the byte in the same entry: one for noise seen during sampling and one for a parity mismatch. The byte at the head of the queue is always on `rd_data`. Its two marks appear on a read-only status byte, `ext_view`. A pulse on `rd_strobe` retires the head, so both the data and the status move on to the next word together.

The block also routes two service conditions to request lines: "receive data available" and "transmitter empty". Each condition has an enable bit and a select bit. With the enable set, the select bit sends the condition to the interrupt line (select 0) or to the DMA request line (select 1). With the enable clear, neither line is raised. All four request outputs are registered.

If a byte arrives while the queue is full, the byte is dropped and a sticky overrun flag is set. A control pulse clears that flag.

Top module: `uart_rxq_steer`

## Requirements
- R1: Bytes leave the queue in arrival order. `rd_data` shows the head byte combinationally, and each `rd_strobe` on a non-empty queue advances to the next byte.
- R2: The noise and parity marks are stored with their own byte. `ext_view` bit 7 is the head word's noise mark and bit 6 is its parity mark, and they advance with the data on each read.
- R3: When the queue is empty, `ext_view` and `rd_data` read zero. Bits 5:0 of `ext_view` always read zero.
- R4: `rx_full` is 1 whenever the queue holds at least one word, and it clears in the cycle after the last word is read.
- R5: A byte that arrives while the queue holds DEPTH words, with no read in the same cycle, is discarded and sets `overrun` in the next cycle. `overrun` stays set until an `ovr_clr` pulse. If a new overflow occurs in the same cycle as the clear, the set wins.
- R6: With `ctl_rx_ie`=1 and the queue non-empty, `rx_irq` is raised one cycle later if `ctl_rx_dma`=0, and `rx_dreq` is raised one cycle later if `ctl_rx_dma`=1. The two lines are never high together.
- R7: With `ctl_rx_ie`=0, neither `rx_irq` nor `rx_dreq` is raised in the following cycle, whatever the value of `ctl_rx_dma`.
- R8: With `ctl_tx_ie`=1 and `tx_empty`=1, `tx_irq` (for `ctl_tx_dma`=0) or `tx_dreq` (for `ctl_tx_dma`=1) is raised one cycle later. With `ctl_tx_ie`=0, neither line is raised.
- R9: An `rd_strobe` while the queue is empty has no effect: the queue stays empty and the outputs stay at zero.
- R10: A byte arriving in the same cycle as a read is always accepted, including when the queue is full. In that case the occupancy is unchanged and `overrun` is not set.
- R11: A synchronous active-high `rst` empties the queue, clears `overrun`, and drives all four request lines low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Byte-received strobe from the receiver core |
| rx_data | input | 8 | Received byte |
| rx_noise | input | 1 | Noise seen on this byte |
| rx_perr | input | 1 | Parity error on this byte |
| rd_strobe | input | 1 | Data register read, retires the head word |
| tx_empty | input | 1 | Transmit holding register empty |
| ctl_rx_ie | input | 1 | Receive request enable |
| ctl_rx_dma | input | 1 | Receive route select: 0 interrupt, 1 DMA |
| ctl_tx_ie | input | 1 | Transmit request enable |
| ctl_tx_dma | input | 1 | Transmit route select: 0 interrupt, 1 DMA |
| ovr_clr | input | 1 | Control write pulse clearing overrun |
| rd_data | output | 8 | Head byte of the queue |
| ext_view | output | 8 | Head word status: bit 7 noise, bit 6 parity, 5:0 zero |
| rx_full | output | 1 | Queue holds at least one word |
| overrun | output | 1 | Sticky overflow flag |
| rx_irq | output | 1 | Receive interrupt request |
| rx_dreq | output | 1 | Receive DMA request |
| tx_irq | output | 1 | Transmit interrupt request |
| tx_dreq | output | 1 | Transmit DMA request |

## Verification
Two functions can occur in the same cycle: a byte arriving from the receiver and a read retiring the head. The sharpest case is when the queue is full. There, the arriving byte must be kept, the occupancy must not change, and `overrun` must stay as it was. The bench first fills the queue to DEPTH with directed writes and then issues a write and a read together. Random traffic later repeats the collision at many occupancies. A reference queue in the bench judges each case: it applies the read before the write, then checks the head byte, the status bits, `rx_full` and `overrun` after every edge. A second collision is also provoked: an overflow in the same cycle as `ovr_clr`, where the bench expects the set to win.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    localparam int DATA_W        = 8;
    localparam int EXT_NOISY_BIT = 7;
    localparam int EXT_PERR_BIT  = 6;

    typedef struct packed {
        logic              noisy;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rxq_entry_t;

    typedef enum logic {
        ROUTE_IRQ = 1'b0,
        ROUTE_DMA = 1'b1
    } route_sel_e;

    // Status byte of the head word; all zero when the queue is empty.
    function automatic logic [7:0] ext_pack(input logic valid, input rxq_entry_t e);
        logic [7:0] v;
        v = '0;
        if (valid) begin
            v[EXT_NOISY_BIT] = e.noisy;
            v[EXT_PERR_BIT]  = e.perr;
        end
        return v;
    endfunction

endpackage

// File: rtl/uart_rxq_fifo.sv
module uart_rxq_fifo
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  rxq_entry_t push_entry,
    input  logic       pop_req,
    input  logic       ovr_clr,
    output rxq_entry_t head,
    output logic       nonempty,
    output logic       full,
    output logic       overrun
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);

    rxq_entry_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_pop, do_push, ovf_evt;

    assign nonempty = (count != '0);
    assign full     = (count == DEPTH_C);
    assign do_pop   = pop_req && nonempty;
    assign do_push  = push && (!full || do_pop);
    assign ovf_evt  = push && full && !do_pop;
    assign head     = nonempty ? mem[rd_ptr] : '0;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_C) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_C) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (ovf_evt)      overrun <= 1'b1;
            else if (ovr_clr) overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rxq_route.sv
module uart_rxq_route
    import uart_rxq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cond,
    input  logic enable,
    input  logic sel,
    output logic irq,
    output logic dreq
);
    route_sel_e route;
    assign route = route_sel_e'(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq  <= 1'b0;
            dreq <= 1'b0;
        end else begin
            irq  <= enable && cond && (route == ROUTE_IRQ);
            dreq <= enable && cond && (route == ROUTE_DMA);
        end
    end
endmodule

// File: rtl/uart_rxq_steer.sv
module uart_rxq_steer
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_noise,
    input  logic       rx_perr,
    input  logic       rd_strobe,
    input  logic       tx_empty,
    input  logic       ctl_rx_ie,
    input  logic       ctl_rx_dma,
    input  logic       ctl_tx_ie,
    input  logic       ctl_tx_dma,
    input  logic       ovr_clr,
    output logic [7:0] rd_data,
    output logic [7:0] ext_view,
    output logic       rx_full,
    output logic       overrun,
    output logic       rx_irq,
    output logic       rx_dreq,
    output logic       tx_irq,
    output logic       tx_dreq
);
    localparam int NSRC = 2;

    rxq_entry_t in_entry, head;
    logic       fifo_full;
    logic [NSRC-1:0] src_cond, src_en, src_sel, src_irq, src_dreq;

    always_comb begin
        in_entry.data  = rx_data;
        in_entry.noisy = rx_noise;
        in_entry.perr  = rx_perr;
    end

    uart_rxq_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk        (clk),
        .rst        (rst),
        .push       (rx_valid),
        .push_entry (in_entry),
        .pop_req    (rd_strobe),
        .ovr_clr    (ovr_clr),
        .head       (head),
        .nonempty   (rx_full),
        .full       (fifo_full),
        .overrun    (overrun)
    );

    assign rd_data  = head.data;
    assign ext_view = ext_pack(rx_full, head);

    // index 0: receive data available, index 1: transmitter empty
    assign src_cond = {tx_empty,   rx_full};
    assign src_en   = {ctl_tx_ie,  ctl_rx_ie};
    assign src_sel  = {ctl_tx_dma, ctl_rx_dma};

    for (genvar g = 0; g < NSRC; g++) begin : g_route
        uart_rxq_route route_i (
            .clk    (clk),
            .rst    (rst),
            .cond   (src_cond[g]),
            .enable (src_en[g]),
            .sel    (src_sel[g]),
            .irq    (src_irq[g]),
            .dreq   (src_dreq[g])
        );
    end

    assign rx_irq  = src_irq[0];
    assign rx_dreq = src_dreq[0];
    assign tx_irq  = src_irq[1];
    assign tx_dreq = src_dreq[1];
endmodule

// File: rtl/uart_rxq_steer_chk.sv
module uart_rxq_steer_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_valid,
    input logic       rd_strobe,
    input logic       ovr_clr,
    input logic       tx_empty,
    input logic       ctl_rx_ie,
    input logic       ctl_tx_ie,
    input logic       ctl_tx_dma,
    input logic       fifo_full,
    input logic       rx_full,
    input logic       overrun,
    input logic [7:0] ext_view,
    input logic       rx_irq,
    input logic       rx_dreq,
    input logic       tx_irq,
    input logic       tx_dreq
);
    // R5
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_full && rx_valid && !rd_strobe |=> overrun);
    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overrun && !ovr_clr |=> overrun);
    // R3
    ext_empty_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_full |-> ext_view == 8'h00);
    // R3
    ext_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        ext_view[5:0] == 6'h00);
    // R6
    rx_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_irq && rx_dreq));
    // R7
    rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_rx_ie |=> !rx_irq && !rx_dreq);
    // R8
    tx_route_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_tx_ie && tx_empty && ctl_tx_dma |=> tx_dreq && !tx_irq);
    // R8
    tx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_tx_ie |=> !tx_irq && !tx_dreq);
    // R9
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_full && rd_strobe && !rx_valid |=> !rx_full);
    // R10
    full_both_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_full && rx_valid && rd_strobe && !ovr_clr |=> fifo_full && $stable(overrun));
endmodule

bind uart_rxq_steer uart_rxq_steer_chk chk_i (.*);

// File: tb/uart_rxq_steer_tb_top.sv
`timescale 1ns/1ps
module uart_rxq_steer_tb_top;
    localparam int DEPTH = 8;

    typedef struct {
        logic [7:0] d;
        logic       n;
        logic       p;
    } mword_t;

    logic clk = 1'b0;
    logic rst;
    logic rx_valid, rx_noise, rx_perr, rd_strobe, tx_empty, ovr_clr;
    logic ctl_rx_ie, ctl_rx_dma, ctl_tx_ie, ctl_tx_dma;
    logic [7:0] rx_data, rd_data, ext_view;
    logic rx_full, overrun, rx_irq, rx_dreq, tx_irq, tx_dreq;

    int compared = 0;
    int mismatched = 0;

    mword_t q[$];
    logic   m_ovr;
    logic   e_rirq, e_rdrq, e_tirq, e_tdrq;

    always #5 clk = ~clk;

    uart_rxq_steer #(.DEPTH(DEPTH)) dut_i (.*);

    function automatic logic [7:0] exp_ext(input mword_t w, input logic valid);
        return valid ? {w.n, w.p, 6'b0} : 8'h00;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string req);
        logic v;
        v = (q.size() != 0);
        chk({req, " R1 rd_data"}, rd_data, v ? q[0].d : 8'h00);
        chk({req, " R2 ext_view"}, ext_view, exp_ext(v ? q[0] : '{8'h0, 1'b0, 1'b0}, v));
        chk({req, " R4 rx_full"}, {7'b0, rx_full}, {7'b0, v});
        chk({req, " R5 overrun"}, {7'b0, overrun}, {7'b0, m_ovr});
        chk({req, " R6 R7 rx req"}, {6'b0, rx_irq, rx_dreq}, {6'b0, e_rirq, e_rdrq});
        chk({req, " R8 tx req"}, {6'b0, tx_irq, tx_dreq}, {6'b0, e_tirq, e_tdrq});
    endtask

    // Drive one cycle at the falling edge, update the model, check at the next falling edge.
    task automatic cyc(input string req, input logic v, input logic [7:0] d,
                       input logic n, input logic p, input logic rd, input logic clr);
        logic pop, full, ovf;
        rx_valid = v; rx_data = d; rx_noise = n; rx_perr = p;
        rd_strobe = rd; ovr_clr = clr;
        e_rirq = ctl_rx_ie && !ctl_rx_dma && (q.size() != 0);
        e_rdrq = ctl_rx_ie &&  ctl_rx_dma && (q.size() != 0);
        e_tirq = ctl_tx_ie && !ctl_tx_dma && tx_empty;
        e_tdrq = ctl_tx_ie &&  ctl_tx_dma && tx_empty;
        pop  = rd && (q.size() != 0);
        full = (q.size() == DEPTH);
        ovf  = v && full && !pop;
        if (pop) void'(q.pop_front());
        if (v && !ovf) q.push_back('{d, n, p});
        if (ovf) m_ovr = 1'b1;
        else if (clr) m_ovr = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_all(req);
    endtask

    initial begin
        #2_000_000;
        mismatched++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        rx_valid = 0; rx_data = 0; rx_noise = 0; rx_perr = 0;
        rd_strobe = 0; tx_empty = 0; ovr_clr = 0;
        ctl_rx_ie = 0; ctl_rx_dma = 0; ctl_tx_ie = 0; ctl_tx_dma = 0;
        m_ovr = 0;
        e_rirq = 0; e_rdrq = 0; e_tirq = 0; e_tdrq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all("R11 reset");

        // R9: read on empty
        cyc("R9 empty read", 0, 8'h00, 0, 0, 1, 0);
        // R2, R1: words with distinct flags, drained in order
        cyc("R2 push", 1, 8'hA1, 1, 0, 0, 0);
        cyc("R2 push", 1, 8'hB2, 0, 1, 0, 0);
        cyc("R2 push", 1, 8'hC3, 1, 1, 0, 0);
        ctl_rx_ie = 1; ctl_rx_dma = 0;
        cyc("R6 irq route", 0, 8'h00, 0, 0, 1, 0);
        ctl_rx_dma = 1;
        cyc("R6 dma route", 0, 8'h00, 0, 0, 1, 0);
        ctl_rx_ie = 0;
        cyc("R7 gated", 0, 8'h00, 0, 0, 1, 0);
        cyc("R4 empty", 0, 8'h00, 0, 0, 0, 0);
        // R5: fill, overflow, clear
        for (int i = 0; i < DEPTH; i++) cyc("R5 fill", 1, 8'(8'h10 + i), i[0], i[1], 0, 0);
        cyc("R5 overflow", 1, 8'hEE, 1, 1, 0, 0);
        cyc("R5 sticky", 0, 8'h00, 0, 0, 0, 0);
        cyc("R5 clr", 0, 8'h00, 0, 0, 0, 1);
        // R10: push and pop together while full
        cyc("R10 full both", 1, 8'h77, 0, 1, 1, 0);
        // R5: overflow together with clear, set wins
        cyc("R5 set wins", 1, 8'h66, 0, 0, 0, 1);
        cyc("R5 clr", 0, 8'h00, 0, 0, 0, 1);
        // R8: tx routing
        tx_empty = 1; ctl_tx_ie = 1; ctl_tx_dma = 0;
        cyc("R8 tx irq", 0, 8'h00, 0, 0, 0, 0);
        ctl_tx_dma = 1;
        cyc("R8 tx dma", 0, 8'h00, 0, 0, 0, 0);
        ctl_tx_ie = 0;
        cyc("R8 tx gated", 0, 8'h00, 0, 0, 0, 0);
        for (int i = 0; i < DEPTH; i++) cyc("R1 drain", 0, 8'h00, 0, 0, 1, 0);
        cyc("R3 empty", 0, 8'h00, 0, 0, 1, 0);

        // constrained random traffic, with phases biased toward filling or draining
        for (int i = 0; i < 3000; i++) begin
            int bias;
            logic v, rd;
            bias = ((i / 200) % 2 == 0) ? 70 : 35;
            v  = ($urandom % 100) < bias;
            rd = ($urandom % 100) < 50;
            ctl_rx_ie  = $urandom;
            ctl_rx_dma = $urandom;
            ctl_tx_ie  = $urandom;
            ctl_tx_dma = $urandom;
            tx_empty   = $urandom;
            cyc("R1 R2 R10 random", v, 8'($urandom), 1'($urandom), 1'($urandom),
                rd, ($urandom % 16) == 0);
        end

        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        q.delete(); m_ovr = 0;
        e_rirq = 0; e_rdrq = 0; e_tirq = 0; e_tdrq = 0;
        check_all("R11 re-reset");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule